// File: doc/BRIEF.md
# Multi-Cycle Processor Datapath

This block is the storage and arithmetic half of a 32-bit processor that spends several clock cycles on each instruction. It executes a small load/store subset: word load, word store, add-immediate, register add, subtract, and, or, branch-if-equal, branch-if-not-equal and jump. One ALU does every sum the instruction needs. That covers the PC increment, the speculative branch target, the effective address and the register arithmetic. Values that must survive from one cycle to the next sit in registers the program cannot see: the instruction register, the two operand latches, the ALU result latch and the memory data latch.

The block makes no decisions of its own. An external control state machine drives every load enable and every multiplexer select on every cycle. It reads back the opcode and function fields and the ALU zero flag. Instruction fetch and data access share one memory port. The address comes from the PC during fetch and from the ALU result latch during a data access. Store data is always the second operand latch. The memory write strobe comes from the control unit and does not pass through this block.

Top module: `mc_datapath`

## Requirements
- R1: Reset is asynchronous and active low. While it is asserted and after it is released, the PC holds RESET_PC (0), and the instruction register, operand latches, result latch, data latch and every register-file entry hold zero.
- R2: Fetch: with addr_sel=0, mem_addr shows the PC. With ir_ld=1, the instruction register captures mem_rdata at the edge. When pc_ld=1, srca_sel=0 (PC), srcb_sel=1 (constant 4), alu_op=0 (add) and pc_sel=0 (ALU result), the same edge moves the PC to PC+4. After the edge, opcode shows IR[31:26] and funct shows IR[5:0].
- R3: Decode: opnd_ld=1 loads operand A from the register that IR[25:21] names and operand B from the register that IR[20:16] names. With srca_sel=0 and srcb_sel=3, the ALU forms PC + (sign-extended IR[15:0] shifted left by 2), and res_ld=1 captures it in the result latch.
- R4: Address: srca_sel=1 (A) with srcb_sel=2 (sign-extended IR[15:0]) and add puts A plus the offset in the result latch. With addr_sel=1, mem_addr shows the result latch.
- R5: Load: mdr_ld=1 captures mem_rdata in the data latch. A following cycle with rf_we=1, wdst_sel=0 (IR[20:16]) and wdata_sel=1 (data latch) writes that value into the register file.
- R6: Store: mem_wdata always shows operand B, so a store sees the value of the register named by IR[20:16].
- R7: Register arithmetic: with srca_sel=1 and srcb_sel=0 (B), alu_op selects 0 add, 1 subtract (A-B), 2 bitwise and, 3 bitwise or. The result latch, written back with wdst_sel=1 (IR[15:11]) and wdata_sel=0, reaches the destination register.
- R8: alu_zero is 1 exactly when the current ALU output is zero, so subtracting B from A flags A==B. pc_ld=1 with pc_sel=1 loads the PC from the result latch (branch taken). pc_ld=0 leaves the PC unchanged (branch not taken).
- R9: Jump: pc_ld=1 with pc_sel=2 loads the PC with {PC[31:28], IR[25:0], 2'b00}. The upper four bits come from the already incremented PC.
- R10: Register 0 always reads as zero, and a write to it has no effect.
- R11: Every hidden register and the PC keep their value in any cycle where their load enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rdata | input | 32 | Read data from the unified memory |
| mem_addr | output | 32 | Memory address: PC or result latch |
| mem_wdata | output | 32 | Store data (operand B) |
| pc_ld | input | 1 | PC load enable |
| ir_ld | input | 1 | Instruction register load enable |
| opnd_ld | input | 1 | Operand A/B load enable |
| res_ld | input | 1 | ALU result latch load enable |
| mdr_ld | input | 1 | Memory data latch load enable |
| rf_we | input | 1 | Register file write enable |
| addr_sel | input | 1 | 0 PC, 1 result latch onto mem_addr |
| srca_sel | input | 1 | ALU input A: 0 PC, 1 operand A |
| srcb_sel | input | 2 | ALU input B: 0 operand B, 1 constant 4, 2 sign-extended offset, 3 offset shifted left 2 |
| alu_op | input | 2 | 0 add, 1 subtract, 2 and, 3 or |
| pc_sel | input | 2 | PC source: 0 ALU output, 1 result latch, 2 jump target |
| wdst_sel | input | 1 | Write register: 0 IR[20:16], 1 IR[15:11] |
| wdata_sel | input | 1 | Write data: 0 result latch, 1 data latch |
| opcode | output | 6 | IR[31:26] |
| funct | output | 6 | IR[5:0] |
| alu_zero | output | 1 | ALU output equals zero |

## Verification
mem_addr, mem_wdata and alu_zero are combinational views of state and of the current selects. The bench reads them in the same cycle the selects are applied, at the falling edge after inputs settle. opcode, funct and every latch capture become visible one rising edge after their enable. A register-file write shows up two instructions later, through the operand latches and the store data port. Branch and jump targets are checked on the next fetch's address, one edge after pc_ld. Each instruction is run as the sequence of cycles a control unit would issue, and a model of the registers and the PC predicts each of these points.

// File: rtl/mc_dp_pkg.sv
package mc_dp_pkg;

   typedef enum logic [1:0] {
      ALU_ADD = 2'd0,
      ALU_SUB = 2'd1,
      ALU_AND = 2'd2,
      ALU_OR  = 2'd3
   } alu_op_e;

   typedef enum logic [1:0] {
      SRCB_OPB   = 2'd0,
      SRCB_FOUR  = 2'd1,
      SRCB_OFS   = 2'd2,
      SRCB_OFSX4 = 2'd3
   } srcb_e;

   typedef enum logic [1:0] {
      PCSRC_ALU  = 2'd0,
      PCSRC_RES  = 2'd1,
      PCSRC_JUMP = 2'd2
   } pcsrc_e;

   localparam int INSN_W = 32;
   localparam int REGIDX_W = 5;

endpackage

// File: rtl/mc_en_reg.sv
module mc_en_reg #(
   parameter int W = 32,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RST_VAL;
      else if (en)
         q <= d;
   end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter int W = 32,
   parameter int NREG = 32,
   parameter bit R0_IS_ZERO = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [4:0]   waddr,
   input  logic [W-1:0] wdata,
   input  logic [4:0]   raddr_a,
   input  logic [4:0]   raddr_b,
   output logic [W-1:0] rdata_a,
   output logic [W-1:0] rdata_b
);
   localparam int IDX_W = $clog2(NREG);

   if (NREG < 2 || NREG > 32 || (1 << IDX_W) != NREG) begin : g_bad_nreg
      $error("mc_regfile: NREG must be a power of two from 2 to 32");
   end

   logic [W-1:0] q [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == 0 && R0_IS_ZERO) begin : g_zero
         assign q[i] = '0;
      end else begin : g_ff
         logic [W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               r <= '0;
            else if (we && waddr[IDX_W-1:0] == IDX_W'(i))
               r <= wdata;
         end
         assign q[i] = r;
      end
   end

   assign rdata_a = q[raddr_a[IDX_W-1:0]];
   assign rdata_b = q[raddr_b[IDX_W-1:0]];
endmodule

// File: rtl/mc_alu.sv
module mc_alu
   import mc_dp_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   output logic [W-1:0] y,
   output logic         zero
);
   always_comb begin
      unique case (op)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         default: y = a + b;
      endcase
   end

   assign zero = (y == '0);
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
   import mc_dp_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int NREG = 32,
   parameter bit R0_IS_ZERO = 1'b1,
   parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] mem_rdata,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic        pc_ld,
   input  logic        ir_ld,
   input  logic        opnd_ld,
   input  logic        res_ld,
   input  logic        mdr_ld,
   input  logic        rf_we,
   input  logic        addr_sel,
   input  logic        srca_sel,
   input  logic [1:0]  srcb_sel,
   input  logic [1:0]  alu_op,
   input  logic [1:0]  pc_sel,
   input  logic        wdst_sel,
   input  logic        wdata_sel,
   output logic [5:0]  opcode,
   output logic [5:0]  funct,
   output logic        alu_zero
);
   localparam int OFS_W = 16;
   localparam int JT_W  = 26;
   localparam int HI_W  = DATA_W - JT_W - 2;

   if (DATA_W != INSN_W) begin : g_bad_width
      $error("mc_datapath: DATA_W must equal the 32-bit instruction width");
   end

   logic [DATA_W-1:0] pc_q, ir_q, a_q, b_q, res_q, mdr_q;
   logic [DATA_W-1:0] pc_d, srca, srcb, alu_y, ofs_sext;
   logic [DATA_W-1:0] rf_a, rf_b, rf_wdata;
   logic [4:0]        rf_waddr;

   mc_en_reg #(.W(DATA_W), .RST_VAL(RESET_PC)) i_pc (
      .clk(clk), .rst_n(rst_n), .en(pc_ld), .d(pc_d), .q(pc_q));
   mc_en_reg #(.W(DATA_W)) i_ir (
      .clk(clk), .rst_n(rst_n), .en(ir_ld), .d(mem_rdata), .q(ir_q));
   mc_en_reg #(.W(DATA_W)) i_opa (
      .clk(clk), .rst_n(rst_n), .en(opnd_ld), .d(rf_a), .q(a_q));
   mc_en_reg #(.W(DATA_W)) i_opb (
      .clk(clk), .rst_n(rst_n), .en(opnd_ld), .d(rf_b), .q(b_q));
   mc_en_reg #(.W(DATA_W)) i_res (
      .clk(clk), .rst_n(rst_n), .en(res_ld), .d(alu_y), .q(res_q));
   mc_en_reg #(.W(DATA_W)) i_mdr (
      .clk(clk), .rst_n(rst_n), .en(mdr_ld), .d(mem_rdata), .q(mdr_q));

   assign rf_waddr = wdst_sel ? ir_q[15:11] : ir_q[20:16];
   assign rf_wdata = wdata_sel ? mdr_q : res_q;

   mc_regfile #(.W(DATA_W), .NREG(NREG), .R0_IS_ZERO(R0_IS_ZERO)) i_rf (
      .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
      .raddr_a(ir_q[25:21]), .raddr_b(ir_q[20:16]),
      .rdata_a(rf_a), .rdata_b(rf_b));

   assign ofs_sext = {{(DATA_W-OFS_W){ir_q[OFS_W-1]}}, ir_q[OFS_W-1:0]};
   assign srca     = srca_sel ? a_q : pc_q;

   always_comb begin
      unique case (srcb_e'(srcb_sel))
         SRCB_OPB:   srcb = b_q;
         SRCB_FOUR:  srcb = DATA_W'(4);
         SRCB_OFS:   srcb = ofs_sext;
         SRCB_OFSX4: srcb = {ofs_sext[DATA_W-3:0], 2'b00};
         default:    srcb = b_q;
      endcase
   end

   mc_alu #(.W(DATA_W)) i_alu (
      .a(srca), .b(srcb), .op(alu_op_e'(alu_op)), .y(alu_y), .zero(alu_zero));

   always_comb begin
      case (pc_sel)
         PCSRC_RES:  pc_d = res_q;
         PCSRC_JUMP: pc_d = {pc_q[DATA_W-1 -: HI_W], ir_q[JT_W-1:0], 2'b00};
         default:    pc_d = alu_y;
      endcase
   end

   assign mem_addr  = addr_sel ? res_q : pc_q;
   assign mem_wdata = b_q;
   assign opcode    = ir_q[31:26];
   assign funct     = ir_q[5:0];
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk #(
   parameter bit R0_IS_ZERO = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        pc_ld,
   input logic        ir_ld,
   input logic        mdr_ld,
   input logic        srca_sel,
   input logic [1:0]  srcb_sel,
   input logic [1:0]  alu_op,
   input logic [1:0]  pc_sel,
   input logic [31:0] mem_rdata,
   input logic [31:0] pc,
   input logic [31:0] ir,
   input logic [31:0] opa,
   input logic [31:0] opb,
   input logic [31:0] mdr,
   input logic [31:0] rf_rd_a,
   input logic        alu_zero
);
   AST_IR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      ir_ld |=> ir == $past(mem_rdata)); // R2

   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_ld && pc_sel == 2'd0 && !srca_sel && srcb_sel == 2'd1 && alu_op == 2'd0)
      |=> pc == $past(pc) + 32'd4); // R2

   AST_MDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      mdr_ld |=> mdr == $past(mem_rdata)); // R5

   AST_EQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (srca_sel && srcb_sel == 2'd0 && alu_op == 2'd1) |-> alu_zero == (opa == opb)); // R8

   AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_ld && pc_sel == 2'd2)
      |=> pc == {$past(pc[31:28]), $past(ir[25:0]), 2'b00}); // R9

   AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pc_ld |=> $stable(pc)); // R11

   AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ir_ld |=> $stable(ir)); // R11

   if (R0_IS_ZERO) begin : g_r0
      AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (ir[25:21] == 5'd0) |-> rf_rd_a == 32'd0); // R10
   end
endmodule

bind mc_datapath mc_datapath_chk #(.R0_IS_ZERO(R0_IS_ZERO)) i_chk (
   .clk(clk), .rst_n(rst_n), .pc_ld(pc_ld), .ir_ld(ir_ld), .mdr_ld(mdr_ld),
   .srca_sel(srca_sel), .srcb_sel(srcb_sel), .alu_op(alu_op), .pc_sel(pc_sel),
   .mem_rdata(mem_rdata), .pc(pc_q), .ir(ir_q), .opa(a_q), .opb(b_q),
   .mdr(mdr_q), .rf_rd_a(rf_a), .alu_zero(alu_zero));

// File: tb/test_mc_datapath.sv
module test_mc_datapath;
   localparam int K_LW = 0, K_SW = 1, K_ADDI = 2, K_ADD = 3, K_SUB = 4,
                  K_AND = 5, K_OR = 6, K_BEQ = 7, K_BNE = 8, K_J = 9;
   localparam int NPROG = 20;
   // entry: kind[66:63] rs[62:58] rt[57:53] rd[52:48] imm[47:32] data[31:0]
   localparam logic [66:0] PROG [NPROG] = '{
      {4'd0, 5'd0,  5'd1,  5'd0, 16'h0008, 32'h0000_0011},
      {4'd0, 5'd0,  5'd2,  5'd0, 16'hFFFC, 32'hF0F0_00FF},
      {4'd3, 5'd1,  5'd2,  5'd3, 16'h0000, 32'h0},
      {4'd5, 5'd2,  5'd3,  5'd4, 16'h0000, 32'h0},
      {4'd6, 5'd1,  5'd2,  5'd6, 16'h0000, 32'h0},
      {4'd4, 5'd2,  5'd1,  5'd7, 16'h0000, 32'h0},
      {4'd1, 5'd1,  5'd3,  5'd0, 16'h000C, 32'h0},
      {4'd1, 5'd0,  5'd4,  5'd0, 16'h0000, 32'h0},
      {4'd1, 5'd7,  5'd6,  5'd0, 16'h0004, 32'h0},
      {4'd1, 5'd1,  5'd7,  5'd0, 16'hFFF0, 32'h0},
      {4'd2, 5'd1,  5'd5,  5'd0, 16'hFFFF, 32'h0},
      {4'd1, 5'd5,  5'd5,  5'd0, 16'h0000, 32'h0},
      {4'd7, 5'd1,  5'd1,  5'd0, 16'h0003, 32'h0},
      {4'd8, 5'd1,  5'd2,  5'd0, 16'h0002, 32'h0},
      {4'd7, 5'd1,  5'd2,  5'd0, 16'h0005, 32'h0},
      {4'd8, 5'd5,  5'd5,  5'd0, 16'h0005, 32'h0},
      {4'd9, 5'd0,  5'd0,  5'd0, 16'h0000, 32'h0000_0010},
      {4'd0, 5'd3,  5'd31, 5'd0, 16'h0000, 32'hA5A5_5A5A},
      {4'd3, 5'd31, 5'd31, 5'd8, 16'h0000, 32'h0},
      {4'd1, 5'd0,  5'd8,  5'd0, 16'h0000, 32'h0}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] mem_rdata, mem_addr, mem_wdata;
   logic        pc_ld, ir_ld, opnd_ld, res_ld, mdr_ld, rf_we;
   logic        addr_sel, srca_sel, wdst_sel, wdata_sel;
   logic [1:0]  srcb_sel, alu_op, pc_sel;
   logic [5:0]  opcode, funct;
   logic        alu_zero;

   int          n_checks = 0;
   int          n_errors = 0;
   bit          finished = 1'b0;
   logic [31:0] mreg [32];
   logic [31:0] mpc;

   always #4 clk = ~clk;

   mc_datapath i_mc_datapath (
      .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .pc_ld(pc_ld), .ir_ld(ir_ld), .opnd_ld(opnd_ld),
      .res_ld(res_ld), .mdr_ld(mdr_ld), .rf_we(rf_we), .addr_sel(addr_sel),
      .srca_sel(srca_sel), .srcb_sel(srcb_sel), .alu_op(alu_op), .pc_sel(pc_sel),
      .wdst_sel(wdst_sel), .wdata_sel(wdata_sel), .opcode(opcode), .funct(funct),
      .alu_zero(alu_zero));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      pc_ld = 0; ir_ld = 0; opnd_ld = 0; res_ld = 0; mdr_ld = 0; rf_we = 0;
      addr_sel = 0; srca_sel = 0; srcb_sel = 2'd0; alu_op = 2'd0; pc_sel = 2'd0;
      wdst_sel = 0; wdata_sel = 0; mem_rdata = 32'h0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [31:0] sext(input logic [15:0] v);
      return {{16{v[15]}}, v};
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
      mpc = 32'h0;
   endtask

   task automatic model_write(input logic [4:0] r, input logic [31:0] v);
      if (r != 5'd0) mreg[r] = v; // R10: writes to register 0 are dropped
   endtask

   task automatic run(input logic [66:0] e);
      int          kind;
      logic [4:0]  rs, rt, rd;
      logic [15:0] imm;
      logic [31:0] data, word, ea, btgt, res;
      logic [5:0]  fn;
      logic        eq, taken;
      kind = int'(e[66:63]); rs = e[62:58]; rt = e[57:53]; rd = e[52:48];
      imm = e[47:32]; data = e[31:0];
      fn = (kind == K_ADD) ? 6'h20 : (kind == K_SUB) ? 6'h22 :
           (kind == K_AND) ? 6'h24 : 6'h25;
      case (kind)
         K_LW:   word = {6'h23, rs, rt, imm};
         K_SW:   word = {6'h2B, rs, rt, imm};
         K_ADDI: word = {6'h08, rs, rt, imm};
         K_BEQ:  word = {6'h04, rs, rt, imm};
         K_BNE:  word = {6'h05, rs, rt, imm};
         K_J:    word = {6'h02, data[25:0]};
         default: word = {6'h00, rs, rt, rd, 5'd0, fn};
      endcase
      // fetch
      idle(); ir_ld = 1; pc_ld = 1; srcb_sel = 2'd1; mem_rdata = word;
      #1 check("R2 fetch address", mem_addr, mpc);
      tick();
      mpc = mpc + 32'd4;
      check("R2 opcode", {26'd0, opcode}, {26'd0, word[31:26]});
      check("R2 funct", {26'd0, funct}, {26'd0, word[5:0]});
      // decode
      idle(); opnd_ld = 1; res_ld = 1; srcb_sel = 2'd3;
      tick();
      btgt = mpc + {sext(imm)[29:0], 2'b00};
      ea = mreg[rs] + sext(imm);
      case (kind)
         K_LW, K_SW: begin
            idle(); srca_sel = 1; srcb_sel = 2'd2; res_ld = 1;
            tick();
            idle(); addr_sel = 1;
            if (kind == K_LW) begin
               mdr_ld = 1; mem_rdata = data;
               #1 check("R4 load address", mem_addr, ea);
               tick();
               idle(); rf_we = 1; wdata_sel = 1;
               tick();
               model_write(rt, data); // R5
            end else begin
               #1 check("R4 store address", mem_addr, ea);
               check("R6 store data", mem_wdata, mreg[rt]);
               tick();
            end
         end
         K_ADDI: begin
            idle(); srca_sel = 1; srcb_sel = 2'd2; res_ld = 1;
            tick();
            idle(); rf_we = 1;
            tick();
            model_write(rt, ea);
         end
         K_BEQ, K_BNE: begin
            idle(); srca_sel = 1; alu_op = 2'd1; addr_sel = 1; pc_sel = 2'd1;
            eq = (mreg[rs] == mreg[rt]);
            taken = (kind == K_BEQ) ? eq : !eq;
            pc_ld = taken;
            #1 check("R8 zero flag", {31'd0, alu_zero}, {31'd0, eq});
            check("R3 branch target in result latch", mem_addr, btgt);
            tick();
            if (taken) mpc = btgt;
         end
         K_J: begin
            idle(); pc_ld = 1; pc_sel = 2'd2;
            tick();
            mpc = {mpc[31:28], data[25:0], 2'b00}; // R9
         end
         default: begin
            idle(); srca_sel = 1; res_ld = 1;
            alu_op = (kind == K_ADD) ? 2'd0 : (kind == K_SUB) ? 2'd1 :
                     (kind == K_AND) ? 2'd2 : 2'd3;
            case (kind) // R7
               K_ADD:   res = mreg[rs] + mreg[rt];
               K_SUB:   res = mreg[rs] - mreg[rt];
               K_AND:   res = mreg[rs] & mreg[rt];
               default: res = mreg[rs] | mreg[rt];
            endcase
            tick();
            idle(); rf_we = 1; wdst_sel = 1;
            tick();
            model_write(rd, res);
         end
      endcase
      idle();
   endtask

   initial begin
      idle();
      rst_n = 0;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1 check("R1 reset PC", mem_addr, 32'h0);
      check("R1 reset opcode", {26'd0, opcode}, 32'd0);
      check("R1 reset operand B", mem_wdata, 32'h0);
      rst_n = 1;
      tick();
      check("R11 PC held with pc_ld low", mem_addr, 32'h0);

      for (int i = 0; i < NPROG; i++) run(PROG[i]); // R2 R3 R4 R5 R6 R7 R8 R9

      // R10: writes aimed at register 0 by each write path
      run({4'd2, 5'd1, 5'd0, 5'd0, 16'h0005, 32'h0});
      run({4'd0, 5'd0, 5'd0, 5'd0, 16'h0020, 32'hDEAD_BEEF});
      run({4'd3, 5'd1, 5'd1, 5'd0, 16'h0000, 32'h0});
      run({4'd1, 5'd0, 5'd0, 5'd0, 16'h0000, 32'h0});

      // R11: operand latches hold while opnd_ld is low
      idle(); addr_sel = 0;
      tick(); tick();
      #1 check("R11 operand B held", mem_wdata, mreg[0]);

      // R1: reset in mid-run clears PC and register file
      idle(); rst_n = 0;
      tick();
      model_reset();
      #1 check("R1 mid-run reset PC", mem_addr, 32'h0);
      check("R1 mid-run reset funct", {26'd0, funct}, 32'd0);
      rst_n = 1;
      tick();
      run({4'd1, 5'd0, 5'd1, 5'd0, 16'h0000, 32'h0});
      // backward branch below zero, then jump keeps upper PC bits (R9)
      run({4'd7, 5'd0, 5'd0, 5'd0, 16'hFFFA, 32'h0});
      run({4'd9, 5'd0, 5'd0, 5'd0, 16'h0000, 32'h0000_0010});
      run({4'd1, 5'd0, 5'd0, 5'd0, 16'h0000, 32'h0});
      check("R9 PC after upper-bit jump", mpc, 32'hF000_0044);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule